// File: doc/BRIEF.md
# Power-Up Mute and Soft-Ramp Sequencer

This block sits between the serial audio receiver and the sigma-delta modulator of a stereo converter. It decides what the modulator sees from reset until audio plays. After reset the output is parked at the most negative code, which is the ground level of the analog stage, and the output clamp is held on. The rest of the data path stays idle, and only the clock-qualification logic runs.

The block arms once the rate detector reports that both the system clock and the frame clock are valid and stay valid for a set number of cycles. It then releases the clamp and raises the output code in equal steps, one step per frame. The ramp ends at mid-scale zero, which is the common-mode level. From then on, left and right samples pass straight through to the modulator. If either clock goes invalid, in any phase, the block falls back to the clamped state at once and restarts the whole sequence.

Top module: `pwrup_ramp_seq`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `clamp_en` is 1 and both DAC outputs hold the most negative code (for 24 bits, 0x800000).
- R2: In the clamped phase, `clamp_en` is 1 and both outputs stay at the most negative code, whatever happens on `frame_tick`, `smp_valid` and the sample inputs.
- R3: The block leaves the clamped phase only after `sys_clk_ok` and `frame_clk_ok` have both been high at QUAL_CYC consecutive clock edges (default 16). Any single edge with either flag low restarts that count. `clamp_en` drops right after the QUAL_CYC-th qualifying edge.
- R4: The ramp phase starts at the most negative code with `clamp_en` at 0. Each edge with `frame_tick` high raises both outputs by 2^(DATA_W-1-RAMP_LOG2), which is 8192 by default. Edges without a tick leave the outputs unchanged.
- R5: After 2^RAMP_LOG2 ticks (1024 by default), both outputs read exactly 0 (mid-scale) and the block is in the run phase. No ramp value is above 0.
- R6: During the ramp, `smp_valid` and the sample inputs have no effect on the outputs.
- R7: In the run phase, an edge with `smp_valid` high loads `smp_left` and `smp_right` onto `dac_left` and `dac_right`, and they are visible after that edge. Without `smp_valid` the outputs hold. Before the first loaded sample they read 0.
- R8: An edge at which either clock-valid flag is low puts the block in the clamped phase after that edge, from any phase. `clamp_en` is 1 and the outputs are at the most negative code. Re-entry needs a fresh qualification (R3), and the ramp restarts from its first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_clk_ok | input | 1 | Rate detector: system clock present and in range |
| frame_clk_ok | input | 1 | Rate detector: frame clock present and in a supported ratio |
| frame_tick | input | 1 | One-cycle pulse per audio frame |
| smp_valid | input | 1 | Qualifies a new stereo sample pair |
| smp_left | input | DATA_W | Left sample, two's complement |
| smp_right | input | DATA_W | Right sample, two's complement |
| dac_left | output | DATA_W | Left code to the modulator, two's complement |
| dac_right | output | DATA_W | Right code to the modulator, two's complement |
| clamp_en | output | 1 | Holds the analog outputs at ground when high |

## Verification
The bench goes after the qualification window with a one-cycle dropout just before it would complete. A design that did not restart its count would release the clamp early. It samples the first and last ramp steps and the step that enters the run phase, which exposes an off-by-one that ends the ramp one frame short or lets it overshoot zero. It feeds valid samples throughout the clamp and ramp phases, so any leak of audio before the run phase shows up as a wrong output code. It also drops each clock flag separately in the ramp and run phases and then reacquires. A design that kept its ramp count, or its last held sample, across that loss would come back at the wrong level.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

    // Sequencer phases; the order is the order of the power-up sequence.
    typedef enum logic [1:0] {
        PH_CLAMP = 2'd0,
        PH_RAMP  = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

    // Next phase from the current phase and the qualifying events.
    // Clock loss overrides every other event.
    function automatic phase_e phase_after(
        input phase_e cur,
        input logic   clocks_ok,
        input logic   qual_done,
        input logic   ramp_done
    );
        phase_e nxt;
        if (!clocks_ok) begin
            nxt = PH_CLAMP;
        end else begin
            unique case (cur)
                PH_CLAMP: nxt = qual_done ? PH_RAMP : PH_CLAMP;
                PH_RAMP:  nxt = ramp_done ? PH_RUN  : PH_RAMP;
                PH_RUN:   nxt = PH_RUN;
                default:  nxt = PH_CLAMP;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/clk_qual.sv
module clk_qual #(
    parameter int QUAL_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic sys_ok,
    input  logic frm_ok,
    input  logic armed,
    output logic clocks_ok,
    output logic qual_done
);
    localparam int QW = (QUAL_CYC > 1) ? $clog2(QUAL_CYC) : 1;
    localparam logic [QW-1:0] LAST = QW'(QUAL_CYC - 1);

    logic [QW-1:0] run_len;

    assign clocks_ok = sys_ok && frm_ok;
    assign qual_done = armed && clocks_ok && (run_len == LAST);

    // Counts consecutive qualifying edges while the sequencer is clamped.
    always_ff @(posedge clk) begin
        if (rst || !armed || !clocks_ok) begin
            run_len <= '0;
        end else if (run_len != LAST) begin
            run_len <= run_len + 1'b1;
        end
    end

    p_qual_reset_r3 : assert property (@(posedge clk) disable iff (rst)
        (!clocks_ok) |=> (run_len == '0));

endmodule

// File: rtl/ramp_gen.sv
module ramp_gen #(
    parameter int DATA_W    = 24,
    parameter int RAMP_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              frame_tick,
    output logic              ramp_done,
    output logic [DATA_W-1:0] ramp_code
);
    // RAMP_LOG2 must not exceed DATA_W-1 so each step is a whole code.
    localparam int SH = DATA_W - 1 - RAMP_LOG2;
    localparam logic [DATA_W-1:0] MIN_CODE = {1'b1, {(DATA_W-1){1'b0}}};

    logic [RAMP_LOG2-1:0] step_cnt;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            step_cnt <= '0;
        end else if (frame_tick) begin
            step_cnt <= step_cnt + 1'b1;
        end
    end

    assign ramp_done = active && frame_tick && (&step_cnt);
    assign ramp_code = MIN_CODE | (DATA_W'(step_cnt) << SH);

    p_idle_count_r2 : assert property (@(posedge clk) disable iff (rst)
        (!active) |=> (step_cnt == '0));

endmodule

// File: rtl/phase_fsm.sv
module phase_fsm
    import pwrup_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clocks_ok,
    input  logic   qual_done,
    input  logic   ramp_done,
    output phase_e phase
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_CLAMP;
        end else begin
            phase <= phase_after(phase, clocks_ok, qual_done, ramp_done);
        end
    end

    p_no_skip_r4 : assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN && $past(phase) != PH_RUN) |-> ($past(phase) == PH_RAMP));

endmodule

// File: rtl/pwrup_ramp_seq.sv
module pwrup_ramp_seq
    import pwrup_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int RAMP_LOG2 = 10,
    parameter int QUAL_CYC  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sys_clk_ok,
    input  logic              frame_clk_ok,
    input  logic              frame_tick,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_left,
    input  logic [DATA_W-1:0] smp_right,
    output logic [DATA_W-1:0] dac_left,
    output logic [DATA_W-1:0] dac_right,
    output logic              clamp_en
);
    localparam int NCH = 2;
    localparam int SH  = DATA_W - 1 - RAMP_LOG2;
    localparam logic [DATA_W-1:0] MIN_CODE = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] STEP_V   = DATA_W'(1) << SH;

    phase_e            phase;
    logic              clocks_ok;
    logic              qual_done;
    logic              ramp_done;
    logic [DATA_W-1:0] ramp_code;
    logic [DATA_W-1:0] smp_in  [NCH];
    logic [DATA_W-1:0] held    [NCH];
    logic [DATA_W-1:0] dac_out [NCH];

    clk_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
        .clk       (clk),
        .rst       (rst),
        .sys_ok    (sys_clk_ok),
        .frm_ok    (frame_clk_ok),
        .armed     (phase == PH_CLAMP),
        .clocks_ok (clocks_ok),
        .qual_done (qual_done)
    );

    ramp_gen #(.DATA_W(DATA_W), .RAMP_LOG2(RAMP_LOG2)) u_ramp (
        .clk        (clk),
        .rst        (rst),
        .active     (phase == PH_RAMP),
        .frame_tick (frame_tick),
        .ramp_done  (ramp_done),
        .ramp_code  (ramp_code)
    );

    phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .clocks_ok (clocks_ok),
        .qual_done (qual_done),
        .ramp_done (ramp_done),
        .phase     (phase)
    );

    assign smp_in[0] = smp_left;
    assign smp_in[1] = smp_right;

    // Per-channel sample hold and output select.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst || phase != PH_RUN) begin
                held[ch] <= '0;
            end else if (smp_valid) begin
                held[ch] <= smp_in[ch];
            end
        end

        always_comb begin
            unique case (phase)
                PH_RAMP: dac_out[ch] = ramp_code;
                PH_RUN:  dac_out[ch] = held[ch];
                default: dac_out[ch] = MIN_CODE;
            endcase
        end
    end

    assign dac_left  = dac_out[0];
    assign dac_right = dac_out[1];
    assign clamp_en  = (phase == PH_CLAMP);

    p_lost_clock_r8 : assert property (@(posedge clk) disable iff (rst)
        (!(sys_clk_ok && frame_clk_ok)) |=> (clamp_en && dac_left == MIN_CODE));

    p_qual_exit_r3 : assert property (@(posedge clk) disable iff (rst)
        ($past(clamp_en) && !clamp_en) |-> $past(sys_clk_ok && frame_clk_ok));

    p_ramp_start_r4 : assert property (@(posedge clk) disable iff (rst)
        ($past(clamp_en) && !clamp_en) |-> (dac_left == MIN_CODE && dac_right == MIN_CODE));

    p_ramp_step_r4 : assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RAMP && $past(phase) == PH_RAMP && $past(frame_tick))
            |-> ((dac_left - $past(dac_left)) == STEP_V));

    p_ramp_still_r6 : assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RAMP && $past(phase) == PH_RAMP && !$past(frame_tick))
            |-> ($stable(dac_left) && $stable(dac_right)));

    p_run_entry_r5 : assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN && $past(phase) == PH_RAMP) |-> (dac_left == '0 && dac_right == '0));

    p_load_r7 : assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN && $past(phase) == PH_RUN && $past(smp_valid))
            |-> (dac_left == $past(smp_left) && dac_right == $past(smp_right)));

    p_hold_r7 : assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN && $past(phase) == PH_RUN && !$past(smp_valid))
            |-> ($stable(dac_left) && $stable(dac_right)));

endmodule

// File: tb/pwrup_ramp_seq_tb.sv
`timescale 1ns/1ps
module pwrup_ramp_seq_tb;
    localparam int W = 24;
    localparam int L = 10;
    localparam int Q = 16;
    localparam int N = 1 << L;
    localparam int STEP = 1 << (W - 1 - L);
    localparam int MINV = -(1 << (W - 1));

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst = 1'b1;
    logic         sys_ok = 1'b0, frm_ok = 1'b0, ftick = 1'b0, sv = 1'b0;
    logic [W-1:0] sl = '0, sr = '0;
    logic [W-1:0] dl, dr;
    logic         clamp;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference state, derived from the requirements.
    int           e_ph = 0;   // 0 clamped, 1 ramp, 2 run
    int           e_q = 0;
    int           e_c = 0;
    logic [W-1:0] e_hl = '0, e_hr = '0;
    string        auto_tag = "R1";

    pwrup_ramp_seq #(.DATA_W(W), .RAMP_LOG2(L), .QUAL_CYC(Q)) u_dut (
        .clk(clk), .rst(rst), .sys_clk_ok(sys_ok), .frame_clk_ok(frm_ok),
        .frame_tick(ftick), .smp_valid(sv), .smp_left(sl), .smp_right(sr),
        .dac_left(dl), .dac_right(dr), .clamp_en(clamp)
    );

    function automatic logic [W-1:0] exp_code(input int ph, input int c, input logic [W-1:0] h);
        if (ph == 0) return W'(MINV);
        if (ph == 1) return W'(MINV + c * STEP);
        return h;
    endfunction

    task automatic model_edge();
        bit ok;
        int old;
        ok = sys_ok && frm_ok;
        old = e_ph;
        if (rst) begin
            e_ph = 0; e_q = 0; e_c = 0; e_hl = '0; e_hr = '0; auto_tag = "R1";
        end else if (!ok) begin
            e_ph = 0; e_q = 0; e_c = 0; e_hl = '0; e_hr = '0;
            auto_tag = (old != 0) ? "R8" : "R2";
        end else begin
            case (e_ph)
                0: begin
                    if (e_q == Q - 1) begin e_ph = 1; e_q = 0; e_c = 0; end
                    else e_q++;
                end
                1: if (ftick) begin
                    if (e_c == N - 1) begin e_ph = 2; e_c = 0; e_hl = '0; e_hr = '0; end
                    else e_c++;
                end
                default: if (sv) begin e_hl = sl; e_hr = sr; end
            endcase
            if (e_ph == 0) auto_tag = "R2";
            else if (e_ph == 1) auto_tag = (old == 0) ? "R3" : "R4,R6";
            else auto_tag = (old == 1) ? "R5" : "R7";
        end
    endtask

    task automatic compare(input string tag);
        logic [2*W:0] act, expv;
        act  = {clamp, dl, dr};
        expv = {(e_ph == 0), exp_code(e_ph, e_c, e_hl), exp_code(e_ph, e_c, e_hr)};
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual clamp/left/right=%h expected=%h at %0t", tag, act, expv, $time);
        end
    endtask

    // One clock: inputs already driven after a falling edge.
    task automatic cyc(input string force_tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare((force_tag != "") ? force_tag : auto_tag);
    endtask

    task automatic rand_samples();
        sl = W'($urandom);
        sr = W'($urandom);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // Reset state
        repeat (3) cyc("R1");
        rst = 1'b0;
        sv = 1'b1; rand_samples();
        cyc("R2");
        // Qualification interrupted one edge short (R3)
        sys_ok = 1'b1; frm_ok = 1'b1;
        for (int i = 0; i < Q - 1; i++) begin rand_samples(); cyc("R3"); end
        frm_ok = 1'b0;
        cyc("R3");
        frm_ok = 1'b1;
        for (int i = 0; i < Q - 1; i++) begin ftick = i[0]; cyc("R3"); end
        ftick = 1'b0;
        cyc("R3");   // Q-th qualifying edge: clamp released, ramp at bottom
        // Full ramp, one tick per cycle, samples offered throughout (R4, R6)
        ftick = 1'b1;
        for (int i = 0; i < N; i++) begin
            sv = $urandom_range(0, 1); rand_samples();
            cyc((i == N - 1) ? "R5" : "");
        end
        ftick = 1'b0; sv = 1'b0;
        cyc("R7");
        // Run with extreme and random samples (R7)
        sv = 1'b1; sl = {1'b0, {(W-1){1'b1}}}; sr = {1'b1, {(W-1){1'b0}}};
        cyc("R7");
        sv = 1'b0; rand_samples();
        cyc("R7");
        for (int i = 0; i < 200; i++) begin
            sv = ($urandom_range(0, 2) == 0); ftick = $urandom_range(0, 1); rand_samples();
            cyc("");
        end
        // Loss of system clock in run (R8)
        sys_ok = 1'b0; cyc("R8");
        sys_ok = 1'b1;
        repeat (Q) cyc("");
        for (int i = 0; i < 300; i++) begin ftick = $urandom_range(0, 1); cyc(""); end
        // Loss of frame clock mid-ramp (R8)
        frm_ok = 1'b0; ftick = 1'b1; cyc("R8");
        frm_ok = 1'b1;
        // Random phase with occasional clock loss and reset
        for (int i = 0; i < 14000; i++) begin
            rst    = ($urandom_range(0, 7999) == 0);
            sys_ok = ($urandom_range(0, 3999) != 0);
            frm_ok = ($urandom_range(0, 3999) != 0);
            ftick  = $urandom_range(0, 1);
            sv     = ($urandom_range(0, 2) == 0);
            rand_samples();
            cyc("");
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 60000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual run still active, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule